// File: doc/BRIEF.md
# Seconds Prescaler and Time Counter with External-Clock Test Mode

This block turns a stream of prescaler steps into one-second increments and counts them in a BCD seconds, minutes and hours chain. Normally the steps come from an internal divided clock that arrives as single-cycle enable pulses. When the test-mode bit is set, rising edges on an asynchronous external pulse pin drive the prescaler in place of the internal steps. A production tester can then run the time chain through many seconds in a few hundred pulses.

The prescaler counts 64 steps for each second. Its reset and hold value is the midpoint of that range. Pulsing the stop bit high and then low therefore puts the count in a known phase. After that, the first second increment arrives after 32 steps and every later one after 64. Any of the three time fields can be written with a BCD value through a shared data bus and one load strobe per field.

Top module: `rtc_presc_top`

## Requirements
- R1: After reset, seconds, minutes and hours read 8'h00, `sec_tick_o` is low, and the prescaler sits at its midpoint. With stop low, the first increment then follows 32 steps.
- R2: With `test_mode_i` high, and after `stop_i` has been raised and then lowered, seconds advance by one after exactly 32 rising edges on `ext_pulse_i`, and not after 31.
- R3: After that first increment, each further increment needs exactly 64 more steps. Two consecutive cycles never both carry `sec_tick_o`.
- R4: While `stop_i` is high, the prescaler is held at its midpoint and no increment occurs, whatever steps arrive. On release, counting resumes from the midpoint.
- R5: With `test_mode_i` low, each single-cycle pulse on `int_tick_i` is one step, and `ext_pulse_i` has no effect.
- R6: With `test_mode_i` high, `int_tick_i` has no effect on the prescaler or the time fields.
- R7: Each field holds two BCD digits, tens in bits 7:4 and units in bits 3:0. Seconds and minutes wrap from 8'h59 to 8'h00 and carry into the next field. Hours wrap from 8'h23 to 8'h00.
- R8: A strobe on `ld_sec_i`, `ld_min_i` or `ld_hr_i` writes `ld_data_i` into that field at the next clock edge, in either mode and whether or not `stop_i` is high.
- R9: `sec_tick_o` is high for exactly one cycle, in the same cycle that the advanced seconds value first appears.
- R10: `ext_pulse_i` passes through a two-flop synchronizer. One step is taken per low-to-high transition, so a level held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_mode_i | input | 1 | 1 selects external pulses as the prescaler step source |
| stop_i | input | 1 | 1 holds the prescaler at its midpoint and blocks increments |
| int_tick_i | input | 1 | Single-cycle step enable from the internal divider |
| ext_pulse_i | input | 1 | Asynchronous external test pulses |
| ld_sec_i | input | 1 | Load strobe for seconds |
| ld_min_i | input | 1 | Load strobe for minutes |
| ld_hr_i | input | 1 | Load strobe for hours |
| ld_data_i | input | 8 | BCD value for the loaded field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hr_o | output | 8 | Hours, BCD |
| sec_tick_o | output | 1 | One-cycle pulse when seconds advance |

## Verification
A prescaler phase that is wrong by even one step shows up at the ports as an increment arriving one pulse early or late. The bench exposes this by stopping at 31 and 63 steps and then adding the final step. A wrong carry or wrap value becomes visible on the next increment that crosses a 59 or 23 boundary, so directed loads put the fields just below those boundaries. A source-selection or stop-gating fault would let stray steps through. It appears as extra `sec_tick_o` pulses, or as time that drifts from the model after random mixes of both pulse sources.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

  typedef logic [7:0] bcd8_t;

  localparam bcd8_t MS_LIMIT = 8'h59;
  localparam bcd8_t HR_LIMIT = 8'h23;

  // Successor of a two-digit BCD value, wrapping to zero at lim.
  function automatic bcd8_t bcd_succ(input bcd8_t v, input bcd8_t lim);
    bcd8_t r;
    if (v == lim) begin
      r = 8'h00;
    end else if (v[3:0] == 4'd9) begin
      r = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_pulse_sync.sv
module rtc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d[0] = async_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_comb begin
        chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               step_i,
  output logic               wrap_o,
  output logic [PRESC_W-1:0] cnt_o
);

  localparam logic [PRESC_W-1:0] MIDPOINT = {1'b1, {(PRESC_W-1){1'b0}}};
  localparam logic [PRESC_W-1:0] TOP      = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;
  logic               cnt_en;

  assign cnt_en = hold_i | step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i) begin
      cnt_d = MIDPOINT;
    end else if (step_i) begin
      cnt_d = cnt_q + {{(PRESC_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MIDPOINT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap_o = step_i & ~hold_i & (cnt_q == TOP);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_presc_pkg::*;
#(
  parameter bcd8_t LIMIT = 8'h59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_i,
  input  bcd8_t ld_val_i,
  input  logic  inc_i,
  output bcd8_t q_o,
  output logic  at_max_o
);

  bcd8_t q_q;
  bcd8_t q_d;
  logic  q_en;

  assign q_en = ld_i | inc_i;

  always_comb begin
    q_d = q_q;
    if (ld_i) begin
      q_d = ld_val_i;
    end else if (inc_i) begin
      q_d = bcd_succ(q_q, LIMIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 8'h00;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o      = q_q;
  assign at_max_o = (q_q == LIMIT);

endmodule

// File: rtl/rtc_presc_top.sv
module rtc_presc_top
  import rtc_presc_pkg::*;
#(
  parameter int PRESC_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_mode_i,
  input  logic       stop_i,
  input  logic       int_tick_i,
  input  logic       ext_pulse_i,
  input  logic       ld_sec_i,
  input  logic       ld_min_i,
  input  logic       ld_hr_i,
  input  logic [7:0] ld_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic       sec_tick_o
);

  localparam int NFIELD = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

  // Step source selection.
  logic ext_rise;
  logic step;
  logic wrap;
  logic [PRESC_W-1:0] presc_cnt;

  rtc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i(ext_pulse_i),
    .rise_o (ext_rise)
  );

  assign step = test_mode_i ? ext_rise : int_tick_i;

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hold_i(stop_i),
    .step_i(step),
    .wrap_o(wrap),
    .cnt_o (presc_cnt)
  );

  // Counter chain: field 0 seconds, 1 minutes, 2 hours.
  logic  [NFIELD-1:0] ld_vec;
  logic  [NFIELD-1:0] at_max;
  logic  [NFIELD-1:0] carry;
  bcd8_t              field_q [NFIELD];

  assign ld_vec = {ld_hr_i, ld_min_i, ld_sec_i};

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_field
      localparam bcd8_t LIM = (g == NFIELD - 1) ? HR_LIMIT : MS_LIMIT;
      if (g == 0) begin : g_first
        assign carry[g] = wrap;
      end else begin : g_rest
        assign carry[g] = wrap & (&at_max[g-1:0]);
      end
      rtc_bcd_field #(.LIMIT(LIM)) u_field (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .ld_i    (ld_vec[g]),
        .ld_val_i(ld_data_i),
        .inc_i   (carry[g]),
        .q_o     (field_q[g]),
        .at_max_o(at_max[g])
      );
    end
  endgenerate

  // Increment strobe, aligned with the new seconds value.
  logic tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap & rst_int_n;
    end
  end

  assign sec_o      = field_q[0];
  assign min_o      = field_q[1];
  assign hr_o       = field_q[2];
  assign sec_tick_o = tick_q;

endmodule

// File: rtl/rtc_presc_chk.sv
module rtc_presc_chk #(
  parameter int PRESC_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop,
  input logic               test_mode,
  input logic               int_tick,
  input logic               ext_rise,
  input logic               ld_sec,
  input logic [PRESC_W-1:0] presc,
  input logic [7:0]         sec,
  input logic [7:0]         hr,
  input logic               sec_tick
);

  localparam logic [PRESC_W-1:0] MIDPOINT = {1'b1, {(PRESC_W-1){1'b0}}};

  assert_stop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (presc == MIDPOINT));

  assert_stop_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);

  assert_ext_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && test_mode && !ext_rise) |=> $stable(presc));

  assert_int_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !test_mode && !int_tick) |=> $stable(presc));

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_tick_moves_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !$past(ld_sec)) |-> (sec != $past(sec)));

  assert_hr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hr <= 8'h23);

  assert_sec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= 8'h59);

endmodule

bind rtc_presc_top rtc_presc_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .stop     (stop_i),
  .test_mode(test_mode_i),
  .int_tick (int_tick_i),
  .ext_rise (ext_rise),
  .ld_sec   (ld_sec_i),
  .presc    (presc_cnt),
  .sec      (sec_o),
  .hr       (hr_o),
  .sec_tick (sec_tick_o)
);

// File: tb/rtc_presc_top_bench.sv
module rtc_presc_top_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       test_mode_i;
  logic       stop_i;
  logic       int_tick_i;
  logic       ext_pulse_i;
  logic       ld_sec_i;
  logic       ld_min_i;
  logic       ld_hr_i;
  logic [7:0] ld_data_i;
  logic [7:0] sec_o;
  logic [7:0] min_o;
  logic [7:0] hr_o;
  logic       sec_tick_o;

  rtc_presc_top u_rtc_presc_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode_i(test_mode_i),
    .stop_i     (stop_i),
    .int_tick_i (int_tick_i),
    .ext_pulse_i(ext_pulse_i),
    .ld_sec_i   (ld_sec_i),
    .ld_min_i   (ld_min_i),
    .ld_hr_i    (ld_hr_i),
    .ld_data_i  (ld_data_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hr_o       (hr_o),
    .sec_tick_o (sec_tick_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int tick_seen = 0;
  bit done = 0;

  // Model state derived from the requirements.
  logic [7:0] m_s, m_m, m_h;
  int         m_p;
  int         m_ticks;

  always @(negedge clk) if (sec_tick_o) tick_seen++;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] v, input logic [7:0] lim);
    if (v == lim) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  task automatic model_advance();
    logic cm, ch;
    cm = (m_s == 8'h59);
    ch = cm && (m_m == 8'h59);
    m_s = nxt(m_s, 8'h59);
    if (cm) m_m = nxt(m_m, 8'h59);
    if (ch) m_h = nxt(m_h, 8'h23);
    m_ticks++;
  endtask

  task automatic model_step();
    if (!stop_i) begin
      m_p++;
      if (m_p == 64) begin
        m_p = 0;
        model_advance();
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_time(input string req);
    check(req, {8'h0, hr_o, min_o, sec_o}, {8'h0, m_h, m_m, m_s});
    check(req, tick_seen, m_ticks);
  endtask

  task automatic ext_pulses(input int n, input int high_cycles);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pulse_i = 1'b1;
      repeat (high_cycles) @(negedge clk);
      ext_pulse_i = 1'b0;
      if (test_mode_i) model_step();
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic int_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); int_tick_i = 1'b1;
      @(negedge clk); int_tick_i = 1'b0;
      if (!test_mode_i) model_step();
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); stop_i = 1'b1;
    repeat (2) @(negedge clk);
    stop_i = 1'b0;
    m_p = 32;
    settle();
  endtask

  task automatic load_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk); ld_data_i = s; ld_sec_i = 1'b1;
    @(negedge clk); ld_sec_i = 1'b0; ld_data_i = m; ld_min_i = 1'b1;
    @(negedge clk); ld_min_i = 1'b0; ld_data_i = h; ld_hr_i = 1'b1;
    @(negedge clk); ld_hr_i = 1'b0;
    m_s = s; m_m = m; m_h = h;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; test_mode_i = 1'b1; stop_i = 1'b0; int_tick_i = 1'b0;
    ext_pulse_i = 1'b0; ld_sec_i = 1'b0; ld_min_i = 1'b0; ld_hr_i = 1'b0;
    ld_data_i = 8'h00;
    m_s = 8'h00; m_m = 8'h00; m_h = 8'h00; m_p = 32; m_ticks = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1: reset state and prescaler midpoint
    check("R1", {8'h0, hr_o, min_o, sec_o}, 32'h0);
    check("R1", sec_tick_o, 1'b0);
    ext_pulses(32, 2); settle();
    check_time("R1");

    // R2 / R3: first increment after 32, then every 64
    restart();
    load_time(8'h10, 8'h20, 8'h30);
    ext_pulses(31, 2); settle();
    check_time("R2");
    check("R2", sec_o, 8'h30);
    ext_pulses(1, 2); settle();
    check("R2", sec_o, 8'h31);
    ext_pulses(63, 2); settle();
    check("R3", sec_o, 8'h31);
    ext_pulses(1, 2); settle();
    check("R3", sec_o, 8'h32);
    check_time("R3");

    // R4: stop mid-count holds, release restarts from midpoint
    ext_pulses(20, 2);
    @(negedge clk); stop_i = 1'b1;
    ext_pulses(100, 2); settle();
    check_time("R4");
    @(negedge clk); stop_i = 1'b0; m_p = 32;
    ext_pulses(31, 2); settle();
    check_time("R4");
    ext_pulses(1, 2); settle();
    check("R4", sec_o, 8'h33);
    check_time("R4");

    // R8: loads while stopped, in internal mode
    @(negedge clk); stop_i = 1'b1; test_mode_i = 1'b0;
    load_time(8'h07, 8'h45, 8'h12);
    settle();
    check("R8", {8'h0, hr_o, min_o, sec_o}, 32'h00074512);

    // R5: internal mode ignores external pulses
    restart();
    ext_pulses(40, 2); settle();
    check_time("R5");
    int_ticks(32); settle();
    check("R5", sec_o, 8'h13);
    check_time("R5");

    // R6: test mode ignores internal ticks
    @(negedge clk); test_mode_i = 1'b1;
    restart();
    int_ticks(100); settle();
    check_time("R6");
    check("R6", sec_o, 8'h13);

    // R7: full rollover of all three fields
    restart();
    load_time(8'h23, 8'h59, 8'h59);
    ext_pulses(32, 2); settle();
    check("R7", {8'h0, hr_o, min_o, sec_o}, 32'h0);
    check_time("R7");
    load_time(8'h09, 8'h59, 8'h59);
    ext_pulses(64, 2); settle();
    check("R7", {8'h0, hr_o, min_o, sec_o}, 32'h00100000);

    // R10: a long high level counts one step
    restart();
    load_time(8'h01, 8'h02, 8'h03);
    ext_pulses(1, 25);
    ext_pulses(30, 2); settle();
    check("R10", sec_o, 8'h03);
    ext_pulses(1, 2); settle();
    check("R10", sec_o, 8'h04);

    // R9: tick count agrees with each increment
    check("R9", tick_seen, m_ticks);

    // Random mixes of modes, loads and both pulse sources
    for (int it = 0; it < 25; it++) begin
      @(negedge clk); test_mode_i = 1'($urandom % 2);
      restart();
      if (it % 4 == 0) begin
        load_time(8'h23, 8'h59, to_bcd(50 + int'($urandom % 10)));
      end else begin
        load_time(to_bcd(int'($urandom % 24)), to_bcd(int'($urandom % 60)),
                  to_bcd(int'($urandom % 60)));
      end
      for (int k = 0; k < 6; k++) begin
        int n;
        n = int'($urandom % 40);
        if ($urandom % 2 == 0) ext_pulses(n, 1 + int'($urandom % 3));
        else int_ticks(n);
      end
      settle();
      check_time(test_mode_i ? "R2" : "R5");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule